// File: doc/BRIEF.md
# Triggered Fractional Rate Divider with Parent Select

This block sets the rate of a derived clock enable. Three parent clocks arrive as enable strobes on a single system clock. A selector picks one parent. An integer pre-divider thins the selected strobes. A main divider with a four-bit fraction then turns them into an output strobe train: every pre-divided tick adds one unit of sixteen to a phase accumulator, and a strobe is emitted each time the accumulator reaches the scaled divisor.

Software writes new values into staging registers, which have no immediate effect. A value becomes active only when a trigger bit commits it. The pre-trigger commits the selector and the pre-divider together. The main trigger commits the main divider. A trigger bit reads 1 from the write until the commit lands. It stays high for at least four cycles, and the commit waits for the next strobe boundary of the stage it changes, so the rate never changes in the middle of a period. A trigger is accepted only while the clock gate input is high. The selector resets to a code that selects no parent, so the output is silent until software chooses a parent.

Top module: `rate_divmux`

## Requirements
- R1: After synchronous reset, both busy flags are 0 and out_stb is 0. The active main divider field is 0, the active pre-divider is 0, and the active selector is 3, which selects no parent.
- R2: While the active selector holds a code of 3 or more, no parent is selected and out_stb stays 0.
- R3: When the active selector holds a valid code s (0..2), only par_stb[s] advances the divider chain. Strobes on the other parents have no effect.
- R4: With active pre-divider value p, exactly one pre-divided tick is produced for every p+1 selected strobes.
- R5: The main field is {integer[11:4], fraction[3:0]} with scaled divisor D = field + 16. Each pre-divided tick adds 16 to the phase. When the new phase would be ≥ D, D is subtracted and out_stb is asserted in the next cycle. The average divide ratio is therefore integer + 1 + fraction/16.
- R6: When wr_addr=2 is written with bit 0 set (main) or bit 1 set (pre) while gate_en is 1 and that trigger is idle, its busy flag reads 1 from the next cycle and stays at 1 for at least 4 cycles.
- R7: The pre-trigger loads the active selector and pre-divider and leaves the main divider unchanged. The main trigger loads only the main divider. No active field changes while its trigger is idle.
- R8: A pending commit lands on the first edge at which the busy minimum is met and a boundary occurs. For the main trigger the boundary is an output strobe; for the pre-trigger it is a pre-divided tick. If the active selector is invalid, the boundary occurs at once. The busy flag falls and the active value changes on that same edge.
- R9: A trigger write made while gate_en is 0 is ignored. The busy flag stays 0 and no active field changes.
- R10: Staging writes use wr_addr=0 for the main field (wr_data[11:0]) and wr_addr=1 for the pre-divider (wr_data[3:0]) and selector (wr_data[5:4]). A commit copies the staged value held before that edge.
- R11: With a pre-divider of 0 and a main field of 0, a selected strobe sampled on one edge makes out_stb read 1 after that edge, and 0 after the next edge if no further strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Clock gate enabled; trigger writes accepted only when high |
| par_stb | input | 3 | Parent clock enable strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 main field, 1 pre/selector, 2 triggers |
| wr_data | input | 12 | Write data |
| out_stb | output | 1 | Divided output rate strobe (registered) |
| main_busy | output | 1 | Main trigger in progress |
| pre_busy | output | 1 | Pre-trigger in progress |
| act_div | output | 12 | Active main divider field |
| act_pre | output | 4 | Active pre-divider field |
| act_sel | output | 2 | Active selector code |

## Verification
The output strobe and each busy flag respond one cycle after the stimulus that causes them. A committed field shows up on the same edge at which its busy flag falls. The bench drives inputs at the falling edge and steps its reference model once per rising edge. It compares every output at the following falling edge, so each result is taken exactly one register stage after its cause. Directed phases count the cycles each busy flag spends high, and they count strobes over windows whose expected totals follow from the divisor arithmetic.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  typedef enum logic [1:0] {
    ADDR_DIV    = 2'd0,
    ADDR_PRESEL = 2'd1,
    ADDR_TRIG   = 2'd2
  } rdm_addr_e;

  localparam int TRG_MAIN = 0;
  localparam int TRG_PRE  = 1;
  localparam int TRG_N    = 2;
endpackage

// File: rtl/rdm_trigger.sv
module rdm_trigger #(
  parameter int MIN_BUSY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic req,
  input  logic boundary,
  output logic busy,
  output logic commit
);
  localparam int CW = (MIN_BUSY > 1) ? $clog2(MIN_BUSY) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_BUSY - 1);

  logic [CW-1:0] cnt;

  assign commit = busy && (cnt == LAST) && boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (req && gate_en) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (commit) begin
      busy <= 1'b0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: gate off means the request is dropped
  p_gate_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && !gate_en) |=> !busy);
  // R6: an accepted request raises busy
  p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && gate_en) |=> busy);
  // R6: busy only falls once the minimum count is reached
  p_min_busy_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/rdm_prediv.sv
module rdm_prediv #(
  parameter int NPAR  = 3,
  parameter int SEL_W = 2,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPAR-1:0]  par_stb,
  input  logic [SEL_W-1:0] sel,
  input  logic [PRE_W-1:0] pre,
  input  logic             clr,
  output logic             sel_valid,
  output logic             pre_hit
);
  localparam int SEL_N = 1 << SEL_W;

  logic [SEL_N-1:0] padded;
  logic [PRE_W-1:0] pcnt;
  logic             sel_stb;

  always_comb begin
    padded = '0;
    padded[NPAR-1:0] = par_stb;
  end

  assign sel_valid = (int'(sel) < NPAR);
  assign sel_stb   = sel_valid && padded[sel];
  assign pre_hit   = sel_stb && (pcnt == pre);

  always_ff @(posedge clk) begin
    if (rst || clr)   pcnt <= '0;
    else if (pre_hit) pcnt <= '0;
    else if (sel_stb) pcnt <= pcnt + 1'b1;
  end

  // R4: the strobe counter never passes the active pre-divider value
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    pcnt <= pre);
endmodule

// File: rtl/rdm_fracdiv.sv
module rdm_fracdiv #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [INT_W+FRAC_W-1:0] div_field,
  input  logic                    clr,
  output logic                    emit,
  output logic                    out_stb
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FRAC_W);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] dscaled;
  logic [ACC_W-1:0] sum;

  assign dscaled = ACC_W'(div_field) + STEP;
  assign sum     = acc + STEP;
  assign emit    = tick && (sum >= dscaled);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      out_stb <= 1'b0;
    end else begin
      out_stb <= emit;
      if (clr)       acc <= '0;
      else if (tick) acc <= emit ? (sum - dscaled) : sum;
    end
  end

  // R5: the phase always stays below the scaled divisor
  p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
    acc < dscaled);
  // R5: a tick whose phase reaches the divisor yields a strobe
  p_emit_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && (sum >= dscaled)) |=> out_stb);
endmodule

// File: rtl/rate_divmux.sv
module rate_divmux
  import rdm_pkg::*;
#(
  parameter int NPAR     = 3,
  parameter int SEL_W    = 2,
  parameter int PRE_W    = 4,
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 4,
  parameter int MIN_BUSY = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    gate_en,
  input  logic [NPAR-1:0]         par_stb,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [INT_W+FRAC_W-1:0] wr_data,
  output logic                    out_stb,
  output logic                    main_busy,
  output logic                    pre_busy,
  output logic [INT_W+FRAC_W-1:0] act_div,
  output logic [PRE_W-1:0]        act_pre,
  output logic [SEL_W-1:0]        act_sel
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam logic [SEL_W-1:0] SEL_RST = {SEL_W{1'b1}};

  logic [DIV_W-1:0] stg_div;
  logic [PRE_W-1:0] stg_pre;
  logic [SEL_W-1:0] stg_sel;

  logic sel_valid, pre_hit, emit;
  logic [TRG_N-1:0] trg_req, trg_bnd, trg_busy, trg_commit;

  // staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_div <= '0;
      stg_pre <= '0;
      stg_sel <= SEL_RST;
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV) stg_div <= wr_data;
      if (wr_addr == ADDR_PRESEL) begin
        stg_pre <= wr_data[PRE_W-1:0];
        stg_sel <= wr_data[PRE_W +: SEL_W];
      end
    end
  end

  // trigger requests and commit boundaries
  always_comb begin
    trg_req[TRG_MAIN] = wr_en && (wr_addr == ADDR_TRIG) && wr_data[TRG_MAIN];
    trg_req[TRG_PRE]  = wr_en && (wr_addr == ADDR_TRIG) && wr_data[TRG_PRE];
    trg_bnd[TRG_MAIN] = emit || !sel_valid;
    trg_bnd[TRG_PRE]  = pre_hit || !sel_valid;
  end

  for (genvar g = 0; g < TRG_N; g++) begin : g_trig
    rdm_trigger #(.MIN_BUSY(MIN_BUSY)) u_trig (
      .clk     (clk),
      .rst     (rst),
      .gate_en (gate_en),
      .req     (trg_req[g]),
      .boundary(trg_bnd[g]),
      .busy    (trg_busy[g]),
      .commit  (trg_commit[g])
    );
  end

  assign main_busy = trg_busy[TRG_MAIN];
  assign pre_busy  = trg_busy[TRG_PRE];

  // active registers
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= '0;
      act_pre <= '0;
      act_sel <= SEL_RST;
    end else begin
      if (trg_commit[TRG_MAIN]) act_div <= stg_div;
      if (trg_commit[TRG_PRE]) begin
        act_pre <= stg_pre;
        act_sel <= stg_sel;
      end
    end
  end

  rdm_prediv #(.NPAR(NPAR), .SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .par_stb  (par_stb),
    .sel      (act_sel),
    .pre      (act_pre),
    .clr      (trg_commit[TRG_PRE]),
    .sel_valid(sel_valid),
    .pre_hit  (pre_hit)
  );

  rdm_fracdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
    .clk      (clk),
    .rst      (rst),
    .tick     (pre_hit),
    .div_field(act_div),
    .clr      (trg_commit[TRG_MAIN] && !sel_valid),
    .emit     (emit),
    .out_stb  (out_stb)
  );

  // R2: no parent selected means no output strobe
  p_dead_sel_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> !out_stb);
  // R7: active main field only moves through its trigger
  p_div_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !main_busy |=> $stable(act_div));
  // R7: selector and pre-divider only move through the pre-trigger
  p_presel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !pre_busy |=> $stable({act_pre, act_sel}));
  // R8: a main commit on a valid parent coincides with an output strobe
  p_main_bound_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_busy) && $past(sel_valid)) |-> out_stb);
endmodule

// File: tb/sim_rate_divmux.sv
module sim_rate_divmux;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_en = 1'b0;
  logic [2:0] par_stb = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic out_stb, main_busy, pre_busy;
  logic [11:0] act_div;
  logic [3:0] act_pre;
  logic [1:0] act_sel;

  always #10 clk = ~clk;

  rate_divmux u0 (
    .clk(clk), .rst(rst), .gate_en(gate_en), .par_stb(par_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_stb(out_stb), .main_busy(main_busy), .pre_busy(pre_busy),
    .act_div(act_div), .act_pre(act_pre), .act_sel(act_sel)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;

  // reference model state
  int m_sdiv, m_spre, m_ssel, m_div, m_pre, m_sel;
  int m_pc, m_acc, m_out, m_mb, m_mc, m_pb, m_pn;

  task automatic chk(input int got, input int exp, input string what);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic m_reset();
    m_sdiv = 0; m_spre = 0; m_ssel = 3; m_div = 0; m_pre = 0; m_sel = 3;
    m_pc = 0; m_acc = 0; m_out = 0; m_mb = 0; m_mc = 0; m_pb = 0; m_pn = 0;
  endtask

  task automatic compare_all();
    chk(int'(out_stb), m_out, "R5 out_stb");
    chk(int'(main_busy), m_mb, "R6 main_busy");
    chk(int'(pre_busy), m_pb, "R6 pre_busy");
    chk(int'(act_div), m_div, "R10 act_div");
    chk(int'(act_pre), m_pre, "R7 act_pre");
    chk(int'(act_sel), m_sel, "R7 act_sel");
  endtask

  // drive one cycle at a falling edge, step the model, compare at next falling edge
  task automatic step(input logic [2:0] ps, input logic we, input logic [1:0] wa,
                      input logic [11:0] wd, input logic g);
    int sv, sstb, phit, dd, sum, emit, mcom, pcom, ntrg;
    par_stb = ps; wr_en = we; wr_addr = wa; wr_data = wd; gate_en = g;
    sv   = (m_sel < 3);
    sstb = sv ? int'(ps[m_sel]) : 0;
    phit = sstb && (m_pc == m_pre);
    dd   = m_div + 16;
    sum  = m_acc + 16;
    emit = phit && (sum >= dd);
    mcom = m_mb && (m_mc == 3) && (emit || !sv);
    pcom = m_pb && (m_pn == 3) && (phit || !sv);
    ntrg = (we && wa == 2'd2 && g) ? int'(wd[1:0]) : 0;
    if (pcom || phit) m_pc = 0; else if (sstb) m_pc = m_pc + 1;
    if (phit) m_acc = emit ? sum - dd : sum; else if (mcom && !sv) m_acc = 0;
    m_out = emit;
    if (!m_mb) begin if (ntrg[0]) begin m_mb = 1; m_mc = 0; end end
    else if (mcom) m_mb = 0; else if (m_mc < 3) m_mc++;
    if (!m_pb) begin if (ntrg[1]) begin m_pb = 1; m_pn = 0; end end
    else if (pcom) m_pb = 0; else if (m_pn < 3) m_pn++;
    if (mcom) m_div = m_sdiv;
    if (pcom) begin m_pre = m_spre; m_sel = m_ssel; end
    if (we && wa == 2'd0) m_sdiv = wd;
    if (we && wa == 2'd1) begin m_spre = wd[3:0]; m_ssel = wd[5:4]; end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input logic [2:0] ps);
    step(ps, 1'b0, 2'd0, 12'h000, 1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n, cnt;
    void'($urandom(32'd5183));
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int'(out_stb), 0, "R1 out_stb");
    chk(int'(main_busy), 0, "R1 main_busy");
    chk(int'(pre_busy), 0, "R1 pre_busy");
    chk(int'(act_div), 0, "R1 act_div");
    chk(int'(act_pre), 0, "R1 act_pre");
    chk(int'(act_sel), 3, "R1 act_sel");
    rst = 1'b0;

    // R2: reset selector picks no parent
    cnt = 0;
    for (int i = 0; i < 12; i++) begin idle(3'b111); cnt += int'(out_stb); end
    chk(cnt, 0, "R2 strobes with invalid selector");

    // R9: triggers written with gate off
    step(3'b000, 1'b1, 2'd1, 12'h010, 1'b0);
    step(3'b000, 1'b1, 2'd2, 12'h003, 1'b0);
    chk(int'(main_busy), 0, "R9 main_busy gate off");
    chk(int'(pre_busy), 0, "R9 pre_busy gate off");
    for (int i = 0; i < 6; i++) idle(3'b000);
    chk(int'(act_sel), 3, "R9 act_sel unchanged");

    // R8: pre commit lands right after minimum busy when selector invalid
    step(3'b000, 1'b1, 2'd2, 12'h002, 1'b1);
    n = 0;
    while (pre_busy && n < 40) begin n++; idle(3'b000); end
    chk(n, 4, "R8 pre busy cycles on idle path");
    chk(int'(act_sel), 1, "R10 selector field committed");

    // R11: single strobe to output latency
    idle(3'b010);
    chk(int'(out_stb), 1, "R11 strobe one cycle later");
    idle(3'b000);
    chk(int'(out_stb), 0, "R11 strobe drops");

    // R3: non-selected parents ignored
    cnt = 0;
    for (int i = 0; i < 10; i++) begin idle(3'b101); cnt += int'(out_stb); end
    chk(cnt, 0, "R3 other parents ignored");

    // R4: pre-divider of 2 gives one tick per three strobes
    step(3'b010, 1'b1, 2'd1, 12'h012, 1'b1);
    step(3'b010, 1'b1, 2'd2, 12'h002, 1'b1);
    while (pre_busy) idle(3'b010);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin idle(3'b010); cnt += int'(out_stb); end
    chk(cnt, 10, "R4 pre-divide by 3");
    step(3'b000, 1'b1, 2'd1, 12'h010, 1'b1);
    step(3'b000, 1'b1, 2'd2, 12'h002, 1'b1);
    while (pre_busy) idle(3'b010);

    // R6/R10/R5: main divisor 2.5
    step(3'b010, 1'b1, 2'd0, 12'h018, 1'b1);
    step(3'b010, 1'b1, 2'd2, 12'h001, 1'b1);
    n = 0;
    while (main_busy && n < 40) begin n++; idle(3'b010); end
    chk(n, 4, "R6 main busy cycles");
    chk(int'(act_div), 12'h018, "R10 main field committed");
    chk(int'(act_sel), 1, "R7 selector untouched by main trigger");
    cnt = 0;
    for (int i = 0; i < 40; i++) begin idle(3'b010); cnt += int'(out_stb); end
    chk(cnt, 16, "R5 divide by 2.5");

    // R8: main commit on an output strobe
    step(3'b010, 1'b1, 2'd0, 12'h000, 1'b1);
    step(3'b010, 1'b1, 2'd2, 12'h001, 1'b1);
    n = 0;
    while (main_busy && n < 40) begin n++; idle(3'b010); end
    chk(int'(out_stb), 1, "R8 commit on output strobe");
    chk(int'(n >= 4), 1, "R8 busy at least minimum");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ps;
      logic we, g;
      logic [1:0] wa;
      logic [11:0] wd;
      ps = 3'($urandom) & 3'($urandom);
      we = ($urandom % 6) == 0;
      wa = 2'($urandom % 3);
      g  = ($urandom % 4) != 0;
      if (wa == 2'd0) wd = 12'((($urandom % 6) << 4) | ($urandom % 16));
      else if (wa == 2'd1) wd = 12'((($urandom % 4) << 4) | ($urandom % 3));
      else wd = 12'($urandom % 4);
      step(ps, we, wa, wd, g);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule